// File: doc/BRIEF.md
# Presettable Decade Counter with Split Enables

This block is one decimal digit of a synchronous counter. On each rising clock edge its registered count moves through the values 0 to 9 and wraps back to 0. The count can be forced to zero at any moment by an active-low clear that does not wait for the clock. An active-low load copies a 4-bit preset value into the count on a clock edge.

Counting is gated by two enables. The first, `en_cnt`, only stops the count from advancing. The second, `en_carry`, also stops the count and in addition gates the carry flag. The carry flag is high only while the digit shows 9 and `en_carry` is high. Several digits form a multi-digit counter when each digit's carry drives the `en_carry` of the digit above it. The control pins are plain levels with no handshake, because no data stream passes through the block.

The actions take effect in this order: clear first, then load, then count, then hold. If a load places a value from 10 to 15 in the count, the next enabled edge returns the count to 0, and the carry flag stays low while such a value is held.

Top module: `bcd_decade`

## Requirements
- R1: With `clear_n`=1, `load_n`=1, `en_cnt`=1 and `en_carry`=1, each rising edge advances the count by one from 0 up to 9. The edge after 9 gives 0.
- R2: When `clear_n` goes low, the count becomes 0 immediately, with no clock edge needed.
- R3: While `clear_n` is low, rising edges leave the count at 0, even when `load_n` is low and both enables are high.
- R4: With `clear_n`=1 and `load_n`=0, a rising edge copies `load_val` into the count. This happens whatever the enable levels are, and the load takes precedence over counting in the same cycle.
- R5: With `clear_n`=1 and `load_n`=1, the count holds across rising edges whenever `en_cnt` or `en_carry` is low.
- R6: `carry_out` is 1 exactly when the count equals 9 (4'b1001) and `en_carry` is 1. `en_cnt` has no effect on it.
- R7: `carry_out` is combinational on the registered count and `en_carry`. It falls and rises with `en_carry` while the count stays at 9, without any clock edge.
- R8: For loaded values 10 to 15, `carry_out` stays 0 and the count holds while counting is disabled. The next enabled edge sets the count to 0.
- R9: Two digits can be chained as follows. Each has `en_cnt`=1; the lower digit has `en_carry`=1; the lower digit's `carry_out` drives the upper digit's `en_carry`. The pair then counts 00 to 99 and wraps to 00. The upper digit's `carry_out` is high only at 99.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous preset, active low |
| load_val | input | 4 | Preset value |
| en_cnt | input | 1 | Count enable that gates counting only |
| en_carry | input | 1 | Count enable that also gates `carry_out` |
| count | output | 4 | Registered digit value |
| carry_out | output | 1 | Terminal-count carry for cascading |

## Verification
Several actions can fall in the same cycle, and the precedence between them is what is checked. A load can meet an active count enable on the same edge, and a clear can be held low while a load is requested. The bench provokes both cases and expects the preset value in the first case and zero in the second. A third case keeps the count at 9 while the carry enable is toggled between edges and `en_cnt` changes independently. There the bench expects `carry_out` to follow only the carry enable at once, and the count to hold.

// File: rtl/bcd_decade_pkg.sv
package bcd_decade_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } digit_op_e;
endpackage

// File: rtl/bcd_step.sv
module bcd_step
  import bcd_decade_pkg::*;
#(
  parameter int unsigned W    = 4,
  parameter int unsigned LAST = 9
) (
  input  logic [W-1:0] cur,
  input  digit_op_e    op,
  input  logic [W-1:0] preset,
  output logic [W-1:0] nxt
);
  always_comb begin
    unique case (op)
      OP_LOAD:  nxt = preset;
      OP_COUNT: nxt = (cur >= W'(LAST)) ? '0 : cur + 1'b1;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/bcd_state_reg.sv
module bcd_state_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) q <= '0;
    else          q <= d;
  end
endmodule

// File: rtl/bcd_carry.sv
module bcd_carry #(
  parameter int unsigned W    = 4,
  parameter int unsigned LAST = 9
) (
  input  logic [W-1:0] cur,
  input  logic         gate,
  output logic         carry
);
  assign carry = gate && (cur == W'(LAST));
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
  import bcd_decade_pkg::*;
#(
  parameter int unsigned MODULUS = 10,
  parameter int unsigned W       = $clog2(MODULUS)
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         load_n,
  input  logic [W-1:0] load_val,
  input  logic         en_cnt,
  input  logic         en_carry,
  output logic [W-1:0] count,
  output logic         carry_out
);
  localparam int unsigned LAST = MODULUS - 1;

  digit_op_e    op;
  logic [W-1:0] nxt;

  always_comb begin
    if (!load_n)                op = OP_LOAD;
    else if (en_cnt && en_carry) op = OP_COUNT;
    else                        op = OP_HOLD;
  end

  bcd_step #(.W(W), .LAST(LAST)) u_step (
    .cur(count), .op(op), .preset(load_val), .nxt(nxt)
  );

  bcd_state_reg #(.W(W)) u_reg (
    .clk(clk), .clear_n(clear_n), .d(nxt), .q(count)
  );

  bcd_carry #(.W(W), .LAST(LAST)) u_carry (
    .cur(count), .gate(en_carry), .carry(carry_out)
  );
endmodule

// File: rtl/bcd_decade_chk.sv
module bcd_decade_chk #(
  parameter int unsigned MODULUS = 10,
  parameter int unsigned W       = 4
) (
  input logic         clk,
  input logic         clear_n,
  input logic         load_n,
  input logic [W-1:0] load_val,
  input logic         en_cnt,
  input logic         en_carry,
  input logic [W-1:0] count,
  input logic         carry_out
);
  localparam logic [W-1:0] LASTV = W'(MODULUS - 1);

  a_r1_wrap: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && en_cnt && en_carry && count == LASTV) |=> count == '0);

  a_r3_clear_hold: assert property (@(posedge clk)
    (!clear_n) |-> count == '0);

  a_r4_load: assert property (@(posedge clk) disable iff (!clear_n)
    (!load_n) |=> count == $past(load_val));

  a_r5_hold: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && !(en_cnt && en_carry)) |=> $stable(count));

  a_r6_carry_value: assert property (@(posedge clk) disable iff (!clear_n)
    carry_out |-> count == LASTV);

  a_r6_carry_gate: assert property (@(posedge clk) disable iff (!clear_n)
    carry_out |-> en_carry);

  a_r8_illegal: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && en_cnt && en_carry && count > LASTV) |=> count == '0);
endmodule

bind bcd_decade bcd_decade_chk #(.MODULUS(MODULUS), .W(W)) u_chk (
  .clk(clk), .clear_n(clear_n), .load_n(load_n), .load_val(load_val),
  .en_cnt(en_cnt), .en_carry(en_carry), .count(count), .carry_out(carry_out)
);

// File: tb/bcd_decade_tb.sv
module bcd_decade_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       clear_n, load_n, en_cnt, en_carry;
  logic [3:0] load_val;
  logic [3:0] count;
  logic       carry_out;

  logic       clear_c;
  logic [3:0] lo_q, hi_q;
  logic       lo_co, hi_co;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_decade u_dut (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .load_val(load_val),
    .en_cnt(en_cnt), .en_carry(en_carry), .count(count), .carry_out(carry_out)
  );

  bcd_decade u_lo (
    .clk(clk), .clear_n(clear_c), .load_n(1'b1), .load_val(4'd0),
    .en_cnt(1'b1), .en_carry(1'b1), .count(lo_q), .carry_out(lo_co)
  );

  bcd_decade u_hi (
    .clk(clk), .clear_n(clear_c), .load_n(1'b1), .load_val(4'd0),
    .en_cnt(1'b1), .en_carry(lo_co), .count(hi_q), .carry_out(hi_co)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    #2;
    check("R2 count at reset", count, 0);
    check("R6 carry at reset", carry_out, 0);
    tick();
    check("R3 edge under clear", count, 0);
    clear_n = 1'b1;
  endtask

  task automatic t_count_wrap();
    for (int i = 1; i <= 12; i++) begin
      tick();
      check("R1 count step", count, i % 10);
      check("R6 carry with count", carry_out, (i % 10 == 9) ? 1 : 0);
    end
  endtask

  task automatic t_async_clear();
    #2;
    clear_n = 1'b0;
    #1;
    check("R2 async clear no edge", count, 0);
    load_n = 1'b0; load_val = 4'd5;
    tick();
    check("R3 clear beats load", count, 0);
    tick();
    check("R3 clear still held", count, 0);
    clear_n = 1'b1; load_n = 1'b1;
  endtask

  task automatic t_load();
    load_n = 1'b0; load_val = 4'd7;
    tick();
    check("R4 load beats count", count, 7);
    en_cnt = 1'b0; en_carry = 1'b0; load_val = 4'd3;
    tick();
    check("R4 load with enables low", count, 3);
    load_n = 1'b1; en_cnt = 1'b1; en_carry = 1'b1;
    tick();
    check("R1 count after load", count, 4);
  endtask

  task automatic t_hold();
    en_cnt = 1'b0;
    tick();
    tick();
    check("R5 hold en_cnt low", count, 4);
    en_cnt = 1'b1; en_carry = 1'b0;
    tick();
    check("R5 hold en_carry low", count, 4);
    en_carry = 1'b1;
    tick();
    check("R5 resume", count, 5);
  endtask

  task automatic t_carry();
    load_n = 1'b0; load_val = 4'd9;
    tick();
    load_n = 1'b1; en_cnt = 1'b0;
    #1;
    check("R6 carry ignores en_cnt", carry_out, 1);
    tick();
    check("R5 hold at nine", count, 9);
    check("R6 carry at nine", carry_out, 1);
    en_carry = 1'b0;
    #1;
    check("R7 carry drops no edge", carry_out, 0);
    en_cnt = 1'b1;
    tick();
    check("R5 hold at nine en_carry low", count, 9);
    check("R7 carry stays low", carry_out, 0);
    en_carry = 1'b1;
    #1;
    check("R7 carry returns no edge", carry_out, 1);
    tick();
    check("R1 wrap from nine", count, 0);
    check("R6 carry after wrap", carry_out, 0);
  endtask

  task automatic t_illegal();
    for (int v = 10; v <= 15; v++) begin
      load_n = 1'b0; load_val = 4'(v); en_cnt = 1'b0; en_carry = 1'b1;
      tick();
      check("R4 load illegal value", count, v);
      check("R8 carry low illegal", carry_out, 0);
      load_n = 1'b1;
      tick();
      check("R8 illegal value holds", count, v);
      en_cnt = 1'b1;
      tick();
      check("R8 illegal to zero", count, 0);
      check("R8 carry after recover", carry_out, 0);
    end
  endtask

  task automatic t_cascade();
    #2;
    clear_c = 1'b1;
    check("R9 cascade start", hi_q * 10 + lo_q, 0);
    for (int k = 1; k <= 120; k++) begin
      tick();
      check("R9 cascade value", hi_q * 10 + lo_q, k % 100);
      check("R9 cascade carry", hi_co, (k % 100 == 99) ? 1 : 0);
    end
  endtask

  initial begin
    clear_n = 1'b0; clear_c = 1'b0; load_n = 1'b1; load_val = 4'd0;
    en_cnt = 1'b1; en_carry = 1'b1;
    t_reset();
    t_count_wrap();
    t_async_clear();
    t_load();
    t_hold();
    t_carry();
    t_illegal();
    t_cascade();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule